// File: doc/BRIEF.md
# Reference-Bit Aging Victim Selector

This block picks which physical page frame to give up when a new page must be brought in. It does not keep exact recency order. Each frame instead carries a use flag that is raised whenever the frame is touched. A periodic sampling pulse then folds every flag into a small per-frame aging register and lowers all the flags in the same step. A frame with a small aging value has been touched rarely, or not recently.

When the miss handler asks for a victim, the block compares all aging values combinationally. It registers the frame with the smallest value, together with that frame's modified status, so that the caller knows whether the outgoing page must be written back first.

Write accesses mark a frame as modified. Selecting a frame as victim marks it clean, since the handler is about to replace its contents. The disk transfer itself and the write-back are outside this block.

Top module: `refbit_victim_sel`

## Requirements
- R1: After a synchronous active-low reset, `victim_valid`, `victim_frame` and `victim_dirty` are 0, and every use flag, aging value and modified flag is 0. A first request therefore returns frame 0, clean.
- R2: A cycle with `acc_valid` high raises the use flag of frame `acc_frame`. Flags of other frames are unchanged until the next tick.
- R3: On a cycle with `tick` high, each frame's 8-bit aging value shifts right by one bit. The frame's use flag enters bit 7, the most significant bit. All use flags are then lowered.
- R4: An access in the same cycle as a tick is not lost. It is the only flag set for the new interval, so it enters bit 7 at the following tick.
- R5: The selected victim is the frame whose aging value, read as an unsigned number, is smallest. Among equal values, the lowest frame index wins.
- R6: `victim_valid` is high in exactly the cycle after a cycle with `victim_req` high. `victim_frame` and `victim_dirty` change only on such cycles and hold their values otherwise.
- R7: An access with `acc_write` high marks its frame modified. `victim_dirty` reports the modified flag of the chosen frame as it stood in the request cycle.
- R8: A request clears the modified flag of the chosen frame. A write access to that same frame in the same cycle wins, and the flag stays set.
- R9: Selection in a request cycle uses the aging values from before that cycle's tick and access updates.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | A frame is accessed this cycle |
| acc_frame | input | 4 | Index of the accessed frame |
| acc_write | input | 1 | The access modifies the frame |
| tick | input | 1 | Sampling pulse: age histories, lower use flags |
| victim_req | input | 1 | Request a replacement victim |
| victim_valid | output | 1 | Victim result is valid this cycle |
| victim_frame | output | 4 | Index of the selected victim frame |
| victim_dirty | output | 1 | Selected frame was modified and needs write-back |

## Verification
A tick and an access can land in the same cycle, and so can a victim request and a write to the chosen frame. The bench drives each of these pairs in directed cycles. It also produces them often in a long random stream, where tick, access, write and request are drawn independently.

A frame-accurate model in the bench judges every outcome. The model applies the documented order: selection from the pre-update histories, the access counted in the new interval, and a same-cycle write winning over the clear. Each request's frame and modified flag are compared with the model.

// File: rtl/refbit_lru_pkg.sv
// Package: shared helpers for the reference-bit aging victim selector.
// Assumes: frame counts of at least 2.
package refbit_lru_pkg;

    // Width of an index able to address n frames.
    function automatic int unsigned idx_bits(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/use_tracker.sv
// Module: use_tracker
// Holds one use flag and one modified flag per frame.
// An access raises its frame's use flag.
// A tick lowers all use flags, but a same-cycle access survives into the new interval.
// A write raises the modified flag. An eviction clears it; a same-cycle write wins.
// Assumes: acc_frame and evict_frame are below N_FRAMES.
module use_tracker #(
    parameter int unsigned N_FRAMES = 16,
    parameter int unsigned IDX_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_valid,
    input  logic [IDX_W-1:0]    acc_frame,
    input  logic                acc_write,
    input  logic                tick,
    input  logic                evict_valid,
    input  logic [IDX_W-1:0]    evict_frame,
    output logic [N_FRAMES-1:0] use_o,
    output logic [N_FRAMES-1:0] dirty_o
);

    logic [N_FRAMES-1:0] acc_hit;
    logic [N_FRAMES-1:0] evict_hit;
    logic [N_FRAMES-1:0] use_q;
    logic [N_FRAMES-1:0] dirty_q;

    // One-hot decode of the accessed and evicted frame per slot.
    for (genvar g = 0; g < N_FRAMES; g++) begin : g_dec
        assign acc_hit[g]   = acc_valid   && (acc_frame   == IDX_W'(g));
        assign evict_hit[g] = evict_valid && (evict_frame == IDX_W'(g));
    end

    // Use flags: accumulate within an interval, restart on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    use_q <= '0;
        else if (tick) use_q <= acc_hit;
        else           use_q <= use_q | acc_hit;
    end

    // Modified flags: set by writes, cleared by eviction, write has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) dirty_q <= '0;
        else        dirty_q <= (dirty_q & ~evict_hit) | (acc_hit & {N_FRAMES{acc_write}});
    end

    assign use_o   = use_q;
    assign dirty_o = dirty_q;

    assert_use_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> use_q[$past(acc_frame)]);

    assert_tick_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !acc_valid) |=> (use_q == '0));

    assert_tick_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && acc_valid) |=> ($countones(use_q) == 1));

    assert_dirty_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write) |=> dirty_q[$past(acc_frame)]);

    assert_dirty_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (evict_valid && !(acc_valid && acc_write && acc_frame == evict_frame))
            |=> !dirty_q[$past(evict_frame)]);

endmodule

// File: rtl/age_history.sv
// Module: age_history
// Keeps one aging register per frame.
// On each tick the register shifts right and the frame's use flag enters the top bit.
// Between ticks the register holds.
// Assumes: AGE_W is at least 2.
module age_history #(
    parameter int unsigned N_FRAMES = 16,
    parameter int unsigned AGE_W    = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            tick,
    input  logic [N_FRAMES-1:0]             use_i,
    output logic [N_FRAMES-1:0][AGE_W-1:0]  hist_o
);

    logic [N_FRAMES-1:0][AGE_W-1:0] hist_q;

    for (genvar g = 0; g < N_FRAMES; g++) begin : g_age
        // Aging shift for frame g on each sampling tick.
        always_ff @(posedge clk) begin
            if (!rst_n)    hist_q[g] <= '0;
            else if (tick) hist_q[g] <= {use_i[g], hist_q[g][AGE_W-1:1]};
        end

        assert_hist_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> (hist_q[g][AGE_W-1] == $past(use_i[g]))
                  && (hist_q[g][AGE_W-2:0] == $past(hist_q[g][AGE_W-1:1])));

        assert_hist_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !tick |=> $stable(hist_q[g]));
    end

    assign hist_o = hist_q;

endmodule

// File: rtl/victim_picker.sv
// Module: victim_picker
// Combinational minimum search over all aging values.
// Strict less-than while scanning upward keeps the lowest index on ties.
// The clock and reset serve only the checks placed here.
// Assumes: N_FRAMES fits in IDX_W bits.
module victim_picker #(
    parameter int unsigned N_FRAMES = 16,
    parameter int unsigned AGE_W    = 8,
    parameter int unsigned IDX_W    = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [N_FRAMES-1:0][AGE_W-1:0]  hist_i,
    output logic [IDX_W-1:0]                sel_o
);

    // Linear scan for the smallest aging value.
    always_comb begin
        sel_o = '0;
        for (int i = 1; i < N_FRAMES; i++) begin
            if (hist_i[i] < hist_i[sel_o]) sel_o = IDX_W'(i);
        end
    end

    for (genvar g = 0; g < N_FRAMES; g++) begin : g_chk
        assert_min_R5: assert property (@(posedge clk) disable iff (!rst_n)
            hist_i[sel_o] <= hist_i[g]);

        assert_tie_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (hist_i[g] == hist_i[sel_o]) |-> (sel_o <= IDX_W'(g)));
    end

endmodule

// File: rtl/refbit_victim_sel.sv
// Module: refbit_victim_sel (top)
// Approximate-LRU victim selector built from use flags and aging histories.
// The victim is picked combinationally from the current histories.
// The picked frame and its modified flag are registered once per request.
// Assumes: requests are issued by a single miss handler. The result is
// valid for one cycle and must be taken then.
module refbit_victim_sel #(
    parameter int unsigned N_FRAMES = 16,
    parameter int unsigned AGE_W    = 8,
    localparam int unsigned IDX_W   = refbit_lru_pkg::idx_bits(N_FRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [IDX_W-1:0] acc_frame,
    input  logic             acc_write,
    input  logic             tick,
    input  logic             victim_req,
    output logic             victim_valid,
    output logic [IDX_W-1:0] victim_frame,
    output logic             victim_dirty
);

    logic [N_FRAMES-1:0]            use_w;
    logic [N_FRAMES-1:0]            dirty_w;
    logic [N_FRAMES-1:0][AGE_W-1:0] hist_w;
    logic [IDX_W-1:0]               sel_w;

    use_tracker #(.N_FRAMES(N_FRAMES), .IDX_W(IDX_W)) u_use (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_valid   (acc_valid),
        .acc_frame   (acc_frame),
        .acc_write   (acc_write),
        .tick        (tick),
        .evict_valid (victim_req),
        .evict_frame (sel_w),
        .use_o       (use_w),
        .dirty_o     (dirty_w)
    );

    age_history #(.N_FRAMES(N_FRAMES), .AGE_W(AGE_W)) u_age (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .use_i  (use_w),
        .hist_o (hist_w)
    );

    victim_picker #(.N_FRAMES(N_FRAMES), .AGE_W(AGE_W), .IDX_W(IDX_W)) u_pick (
        .clk    (clk),
        .rst_n  (rst_n),
        .hist_i (hist_w),
        .sel_o  (sel_w)
    );

    // Result valid strobe, one cycle after each request.
    always_ff @(posedge clk) begin
        if (!rst_n) victim_valid <= 1'b0;
        else        victim_valid <= victim_req;
    end

    // Capture the chosen frame and its modified flag on a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            victim_frame <= '0;
            victim_dirty <= 1'b0;
        end else if (victim_req) begin
            victim_frame <= sel_w;
            victim_dirty <= dirty_w[sel_w];
        end
    end

    assert_resp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        victim_req |=> victim_valid);

    assert_no_resp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !victim_req |=> (!victim_valid && $stable(victim_frame) && $stable(victim_dirty)));

endmodule

// File: tb/test_refbit_victim_sel.sv
`timescale 1ns/1ps
module test_refbit_victim_sel;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_valid = 1'b0;
    logic [3:0] acc_frame = '0;
    logic       acc_write = 1'b0;
    logic       tick = 1'b0;
    logic       victim_req = 1'b0;
    logic       victim_valid;
    logic [3:0] victim_frame;
    logic       victim_dirty;

    int n_vec  = 0;
    int n_fail = 0;

    logic [7:0] hm [16];
    bit         um [16];
    bit         dm [16];

    always #2.5 clk = ~clk;

    refbit_victim_sel i_refbit_victim_sel (
        .clk          (clk),
        .rst_n        (rst_n),
        .acc_valid    (acc_valid),
        .acc_frame    (acc_frame),
        .acc_write    (acc_write),
        .tick         (tick),
        .victim_req   (victim_req),
        .victim_valid (victim_valid),
        .victim_frame (victim_frame),
        .victim_dirty (victim_dirty)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One cycle of stimulus: drive, predict, update model, check.
    task automatic step(input bit av, input int af, input bit aw,
                        input bit tk, input bit rq, input string tag);
        int best;
        bit exp_d;
        @(negedge clk);
        acc_valid = av; acc_frame = 4'(af); acc_write = aw;
        tick = tk; victim_req = rq;
        best = 0;
        for (int i = 1; i < 16; i++) if (hm[i] < hm[best]) best = i;
        exp_d = dm[best];
        if (rq) dm[best] = 1'b0;
        if (av && aw) dm[af] = 1'b1;
        if (tk) begin
            for (int i = 0; i < 16; i++) begin
                hm[i] = {um[i], hm[i][7:1]};
                um[i] = 1'b0;
            end
        end
        if (av) um[af] = 1'b1;
        @(posedge clk);
        #1;
        check("R6 valid", int'(victim_valid), int'(rq));
        if (rq) begin
            check({tag, " frame"}, int'(victim_frame), best);
            check({"R7 dirty/", tag}, int'(victim_dirty), int'(exp_d));
        end
        acc_valid = 0; tick = 0; victim_req = 0; acc_write = 0;
    endtask

    initial begin
        #(5.0 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin hm[i] = '0; um[i] = 0; dm[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state at the ports.
        check("R1 valid", int'(victim_valid), 0);
        check("R1 frame", int'(victim_frame), 0);
        check("R1 dirty", int'(victim_dirty), 0);
        step(0, 0, 0, 0, 1, "R1");
        // R2/R3/R5: each frame in turn left untouched for one interval.
        for (int f = 0; f < 16; f++) begin
            for (int k = 0; k < 16; k++) if (k != f) step(1, k, 0, 0, 0, "R2");
            step(0, 0, 0, 1, 0, "R3");
            step(0, 0, 0, 0, 1, "R3");
        end
        // R5: tie breaking after full flush to equal histories.
        for (int t = 0; t < 8; t++) step(0, 0, 0, 1, 0, "R5");
        step(0, 0, 0, 0, 1, "R5");
        // R4: access in a tick cycle counts in the next interval.
        for (int k = 1; k < 16; k++) step(1, k, 0, 0, 0, "R4");
        step(1, 0, 0, 1, 0, "R4");
        step(0, 0, 0, 0, 1, "R4");
        step(0, 0, 0, 1, 0, "R4");
        step(0, 0, 0, 0, 1, "R4");
        // R9: request together with a tick and an access.
        step(1, 5, 0, 1, 1, "R9");
        step(0, 0, 0, 0, 1, "R9");
        // R7/R8: write marks dirty, eviction clears, same-cycle write wins.
        for (int t = 0; t < 8; t++) step(0, 0, 0, 1, 0, "R8");
        step(1, 0, 1, 0, 1, "R8");
        step(0, 0, 0, 0, 1, "R8");
        step(0, 0, 0, 0, 1, "R8");
        step(1, 0, 1, 0, 0, "R7");
        step(0, 0, 0, 0, 1, "R7");
        step(0, 0, 0, 0, 1, "R8");
        // R5/R6/R7/R8: long random mix of all inputs.
        for (int n = 0; n < 6000; n++) begin
            int r;
            r = $urandom;
            step(r[0] | r[1], int'(r[7:4]), r[2], (r[11:8] == 0),
                 (r[14:12] == 0), "R5");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule